// File: doc/BRIEF.md
# Width-Narrowing DDR Link Transmitter

This block sits at the sending end of a chip-to-chip parallel link. Wide words arrive on an internal write port that uses a valid/ready handshake. They are held in a small buffer with two ports. The write side of that buffer takes a whole wide word. The read side hands out one narrow slice per clock. Each slice is split into two halves, and the halves go out on the external pins at double data rate: one half while the clock is high and the other half while it is low. An identical output cell drives each external pin, and the cells are replicated across the bus.

A forwarded clock travels next to the data so that the far end can capture it. A valid line marks every period that carries a slice. When the buffer is empty, or when the link is disabled, the block sends nothing: valid stays low and the data pins stay at zero. The number of periods needed to move one word grows with the ratio of the wide width to the narrow width.

Top module: `ddr_link_tx`

## Requirements
- R1: A wide word is accepted on a rising edge where both `wr_valid_i` and `wr_ready_o` are high. `wr_ready_o` is low exactly when the buffer holds DEPTH words, counting a word that has been partly sent.
- R2: Each wide word is sent as IN_W/(2*PIN_W) slices. Slices go out least-significant first, and slice k is bits [k*2*PIN_W +: 2*PIN_W]. Words leave in the order they were accepted.
- R3: Within a period that carries a slice, the pins show bits [PIN_W-1:0] of the slice while the clock is high and bits [2*PIN_W-1:PIN_W] while the clock is low.
- R4: `tx_valid_o` is high for the whole of every period that carries a slice and low otherwise. In a period where it is low, `tx_data_o` is zero in both phases.
- R5: No slice is sent while the buffer is empty. While `link_en_i` is low at a rising edge, no slice is consumed at that edge and the buffered data is kept for later.
- R6: `tx_clk_o` follows the clock's high phase during a period that begins with a rising edge at which `link_en_i` was high. In any other period it stays low.
- R7: While `rst_ni` is low, the buffer is empty, `tx_valid_o`, `tx_data_o` and `tx_clk_o` are all zero, and `wr_ready_o` is high.
- R8: Suppose a word is written into an empty buffer while the link is enabled. Its first slice occupies the period that starts one rising edge after the accepting edge. Its last slice ends exactly IN_W/(2*PIN_W) periods after that.
- R9: A full buffer only frees space when the last slice of its oldest word is sent. Sending earlier slices leaves `wr_ready_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Link clock; both phases carry data |
| rst_ni | input | 1 | Asynchronous reset, active low |
| link_en_i | input | 1 | Enables reading slices and the forwarded clock |
| wr_valid_i | input | 1 | Wide write request |
| wr_ready_o | output | 1 | Buffer has room for a wide word |
| wr_data_i | input | IN_W | Wide write word |
| tx_clk_o | output | 1 | Forwarded clock |
| tx_valid_o | output | 1 | Marks periods that carry a slice |
| tx_data_o | output | PIN_W | DDR data pins |

## Verification
The bench fills the buffer while the link is off and then tries to write more. A design that counted a partly-sent word as free space would take a write too early and then overwrite unsent data. The bench toggles the link enable in the middle of a word. If a slice were consumed during a stall, the next beats would arrive out of order or with a slice missing. It checks both clock phases in every period: if the halves were swapped, or slices were taken most-significant first, every beat would differ from the reference. It also checks that the pins fall to zero when idle and that the first beat appears after the exact number of periods. A design that left stale data on the pins, or that added a pipeline stage, would be reported there.

// File: rtl/ddr_link_pkg.sv
package ddr_link_pkg;
  // slices per wide word; pin_w bits leave on each clock phase
  function automatic int unsigned slices_per_word(int unsigned in_w, int unsigned pin_w);
    return in_w / (2 * pin_w);
  endfunction
endpackage

// File: rtl/width_narrow_fifo.sv
module width_narrow_fifo #(
  parameter int unsigned IN_W  = 32,
  parameter int unsigned NW    = 8,
  parameter int unsigned DEPTH = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_valid_i,
  output logic            wr_ready_o,
  input  logic [IN_W-1:0] wr_data_i,
  input  logic            rd_en_i,
  output logic [NW-1:0]   rd_data_o,
  output logic            empty_o
);
  localparam int unsigned RATIO = IN_W / NW;
  localparam int unsigned SW    = $clog2(RATIO);
  localparam int unsigned AW    = $clog2(DEPTH);
  localparam int unsigned PW    = AW + SW + 1;

  logic [IN_W-1:0] mem [DEPTH];
  logic [AW:0]     wr_ptr;
  logic [PW-1:0]   rd_ptr;
  logic [AW:0]     rd_word;
  logic [SW-1:0]   rd_slice;
  logic            full, wr_fire, rd_fire, last_slice;

  assign rd_word    = rd_ptr[PW-1:SW];
  assign rd_slice   = rd_ptr[SW-1:0];
  assign empty_o    = (wr_ptr == rd_word);
  assign full       = (wr_ptr == {~rd_word[AW], rd_word[AW-1:0]});
  assign wr_ready_o = !full;
  assign wr_fire    = wr_valid_i && !full;
  assign rd_fire    = rd_en_i && !empty_o;
  assign last_slice = (rd_slice == SW'(RATIO - 1));
  assign rd_data_o  = mem[rd_word[AW-1:0]][rd_slice*NW +: NW];

  always_ff @(posedge clk_i) begin
    if (wr_fire) mem[wr_ptr[AW-1:0]] <= wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (wr_fire) wr_ptr <= wr_ptr + 1'b1;
      if (rd_fire) rd_ptr <= rd_ptr + 1'b1;
    end
  end

  // R1
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_i && !wr_ready_o) |=> (wr_ptr == $past(wr_ptr)));

  // R2
  slice_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !empty_o) |=> (rd_ptr == PW'($past(rd_ptr) + 1'b1)));

  // R9
  full_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full && !(rd_fire && last_slice)) |=> !wr_ready_o);
endmodule

// File: rtl/ddr_out_cell.sv
module ddr_out_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rise_d_i,
  input  logic fall_d_i,
  output logic rise_q_o,
  output logic fall_q_o,
  output logic pin_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rise_q_o <= 1'b0;
      fall_q_o <= 1'b0;
    end else begin
      rise_q_o <= rise_d_i;
      fall_q_o <= fall_d_i;
    end
  end

  // high phase carries the rise bit, low phase the fall bit
  assign pin_o = clk_i ? rise_q_o : fall_q_o;
endmodule

// File: rtl/ddr_link_tx.sv
module ddr_link_tx
  import ddr_link_pkg::*;
#(
  parameter int unsigned IN_W  = 32,
  parameter int unsigned PIN_W = 4,
  parameter int unsigned DEPTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             link_en_i,
  input  logic             wr_valid_i,
  output logic             wr_ready_o,
  input  logic [IN_W-1:0]  wr_data_i,
  output logic             tx_clk_o,
  output logic             tx_valid_o,
  output logic [PIN_W-1:0] tx_data_o
);
  localparam int unsigned NW    = 2 * PIN_W;
  localparam int unsigned RATIO = slices_per_word(IN_W, PIN_W);

  logic [NW-1:0]    rd_slice;
  logic             fifo_empty, pop;
  logic [PIN_W-1:0] rise_d, fall_d, rise_bus, fall_bus;
  logic             valid_rq, valid_fq, clk_rq, clk_fq;

  assign pop = link_en_i && !fifo_empty;

  width_narrow_fifo #(.IN_W(IN_W), .NW(IN_W / RATIO), .DEPTH(DEPTH)) u_fifo (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_valid_i (wr_valid_i),
    .wr_ready_o (wr_ready_o),
    .wr_data_i  (wr_data_i),
    .rd_en_i    (link_en_i),
    .rd_data_o  (rd_slice),
    .empty_o    (fifo_empty)
  );

  assign rise_d = pop ? rd_slice[PIN_W-1:0]  : '0;
  assign fall_d = pop ? rd_slice[NW-1:PIN_W] : '0;

  for (genvar b = 0; b < PIN_W; b++) begin : g_bit
    ddr_out_cell u_cell (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .rise_d_i (rise_d[b]),
      .fall_d_i (fall_d[b]),
      .rise_q_o (rise_bus[b]),
      .fall_q_o (fall_bus[b]),
      .pin_o    (tx_data_o[b])
    );
  end

  ddr_out_cell u_valid (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rise_d_i (pop),
    .fall_d_i (pop),
    .rise_q_o (valid_rq),
    .fall_q_o (valid_fq),
    .pin_o    (tx_valid_o)
  );

  // forwarded clock: same cell, high in rise phase only while enabled
  ddr_out_cell u_fwd_clk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rise_d_i (link_en_i),
    .fall_d_i (1'b0),
    .rise_q_o (clk_rq),
    .fall_q_o (clk_fq),
    .pin_o    (tx_clk_o)
  );

  // R4
  idle_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_rq |-> (rise_bus == '0 && fall_bus == '0 && !valid_fq));

  // R5
  empty_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_empty || !link_en_i) |=> !valid_rq);

  // R6
  fwd_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !link_en_i |=> (!clk_rq && !clk_fq));
endmodule

// File: tb/tb_ddr_link_tx.sv
module tb_ddr_link_tx;
  localparam int IN_W  = 32;
  localparam int PIN_W = 4;
  localparam int DEPTH = 4;
  localparam int NW    = 2 * PIN_W;
  localparam int RATIO = IN_W / NW;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic link_en = 1'b0;
  logic wr_valid = 1'b0;
  logic [IN_W-1:0] wr_data = '0;
  logic wr_ready, tx_clk, tx_valid;
  logic [PIN_W-1:0] tx_data;

  int n_chk = 0;
  int n_fail = 0;
  logic [IN_W-1:0] wq[$];
  int sidx = 0;
  logic exp_valid = 1'b0, exp_fwd = 1'b0;
  logic [PIN_W-1:0] exp_lo = '0, exp_hi = '0;
  int unsigned seed = 32'h1234_5678;

  always #4 clk = ~clk;

  ddr_link_tx #(.IN_W(IN_W), .PIN_W(PIN_W), .DEPTH(DEPTH)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .link_en_i(link_en),
    .wr_valid_i(wr_valid), .wr_ready_o(wr_ready), .wr_data_i(wr_data),
    .tx_clk_o(tx_clk), .tx_valid_o(tx_valid), .tx_data_o(tx_data)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s at %0t: actual=%h expected=%h", tag, $time, act, exp);
    end
  endtask

  function automatic logic [IN_W-1:0] next_word();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed;
  endfunction

  // one clock period: drive, model the edge, check high then low phase
  task automatic step(input logic v, input logic [IN_W-1:0] d, input logic en);
    logic pop, acc;
    logic [NW-1:0] s;
    wr_valid = v; wr_data = d; link_en = en;
    @(posedge clk);
    pop = (wq.size() > 0) && en;
    acc = v && (wq.size() < DEPTH);
    if (pop) begin
      s = wq[0][sidx*NW +: NW];
      exp_valid = 1'b1; exp_lo = s[PIN_W-1:0]; exp_hi = s[NW-1:PIN_W];
      sidx++;
      if (sidx == RATIO) begin
        void'(wq.pop_front());
        sidx = 0;
      end
    end else begin
      exp_valid = 1'b0; exp_lo = '0; exp_hi = '0;
    end
    if (acc) wq.push_back(d);
    exp_fwd = en;
    #2;
    chk("R4 valid high phase", 32'(tx_valid), 32'(exp_valid));
    chk("R2,R3 data high phase", 32'(tx_data), 32'(exp_lo));
    chk("R6 fwd clk high phase", 32'(tx_clk), 32'(exp_fwd));
    chk("R1 ready", 32'(wr_ready), 32'(wq.size() < DEPTH));
    #4;
    chk("R4 valid low phase", 32'(tx_valid), 32'(exp_valid));
    chk("R3 data low phase", 32'(tx_data), 32'(exp_hi));
    chk("R6 fwd clk low phase", 32'(tx_clk), 32'd0);
  endtask

  initial begin
    #(200000 * 8);
    n_fail++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    // R7 reset state, both phases, with inputs active
    link_en = 1'b1; wr_valid = 1'b1; wr_data = 32'hFFFF_FFFF;
    repeat (3) @(posedge clk);
    #2;
    chk("R7 valid in reset", 32'(tx_valid), 32'd0);
    chk("R7 data in reset", 32'(tx_data), 32'd0);
    chk("R7 fwd clk in reset", 32'(tx_clk), 32'd0);
    chk("R7 ready in reset", 32'(wr_ready), 32'd1);
    #4;
    chk("R7 data low phase in reset", 32'(tx_data), 32'd0);
    wr_valid = 1'b0; link_en = 1'b0;
    rst_ni = 1'b1;

    // R8 latency of one word into an empty buffer
    step(1'b1, 32'hA7B6_C5D4, 1'b1);
    chk("R8 no beat on accepting period", 32'(tx_valid), 32'd0);
    for (int i = 0; i < RATIO; i++) begin
      step(1'b0, '0, 1'b1);
      chk("R8 beat present", 32'(tx_valid), 32'd1);
    end
    step(1'b0, '0, 1'b1);
    chk("R8 word done after ratio periods", 32'(tx_valid), 32'd0);

    // fill with link off, overrun attempts
    for (int i = 0; i < DEPTH + 2; i++) step(1'b1, next_word(), 1'b0);
    chk("R1 ready low when full", 32'(wr_ready), 32'd0);
    for (int i = 0; i < RATIO - 1; i++) begin
      step(1'b1, next_word(), 1'b1);
      chk("R9 still full mid-word", 32'(wr_ready), 32'd0);
    end
    step(1'b0, '0, 1'b1);
    chk("R9 space after last slice", 32'(wr_ready), 32'd1);

    // drain with sparse writes
    for (int i = 0; i < 24; i++) step(i[1], next_word(), 1'b1);

    // stalls mid-word, mixed traffic
    for (int i = 0; i < 80; i++) begin
      logic [IN_W-1:0] w;
      w = next_word();
      step(w[3], next_word(), w[9] | w[17]);
    end

    // R5 disabled link keeps data, then drains
    for (int i = 0; i < 6; i++) begin
      step(1'b1, next_word(), 1'b0);
      chk("R5 no beat while disabled", 32'(tx_valid), 32'd0);
    end
    for (int i = 0; i < (DEPTH + 1) * RATIO + 2; i++) step(1'b0, '0, 1'b1);
    step(1'b0, '0, 1'b1);
    chk("R5 no beat when empty", 32'(tx_valid), 32'd0);
    chk("R4 pins zero when idle", 32'(tx_data), 32'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule